// File: doc/BRIEF.md
# Video DRAM contention wait-state generator

This block sits between a processor and a DRAM that it shares with a video fetcher and a refresh engine. It keeps the raster position, a cycle counter within the line and a line counter within the frame. From that position it derives when the fetcher occupies the memory: each line is cut into equal chunks, and a chunk is either a busy slot (the fetcher holds the memory for its first part and leaves the rest free) or fully free. Video lines carry many busy slots. Non-video lines carry only a few refresh slots, placed at the start of the line.

When the processor starts a byte or word access, the block does not grant it after a fixed number of wait states. It samples the slot pattern at a decision cycle that depends on the direction: two cycles in for a read, three for a write. It then looks four cycles ahead. A clear window completes the access at once. Otherwise the access is parked until the next busy slot has drained. The processor is held only by withholding a one-cycle acknowledge pulse. A word access is split into two byte accesses, and each one is judged against its own position in the line.

A parameter applies the video-line slot pattern to every line, so that the refresh-only timing can be compared with a full-penalty alternative.

Top module: `vram_wait_gen`

## Requirements
- R1: After reset, `cyclePos` and `linePos` are 0. `cyclePos` counts up once per clock and wraps from 479 to 0. `linePos` goes up by one on that wrap and wraps from 311 to 0. It holds its value at all other times.
- R2: The chunk is `cyclePos / 12` and the chunk cycle is `cyclePos % 12`. On lines 0 to 255, `fetchBusy` is 1 exactly when the chunk is below 32 and the chunk cycle is below 8.
- R3: With `FULL_PENALTY = 0`, on lines 256 to 311 `fetchBusy` is 1 exactly when the chunk is below 8 and the chunk cycle is below 8.
- R4: With `FULL_PENALTY = 1`, lines 256 to 311 follow the same slot pattern as lines 0 to 255.
- R5: An access starts in cycle t0, the cycle in which `reqValid` is 1 while the block is idle. `reqRead = 1` marks a read and puts the decision cycle at d = t0 + 2. `reqRead = 0` marks a write and puts it at d = t0 + 3.
- R6: If `fetchBusy` is 0 in each of the cycles d, d+1, d+2 and d+3, the byte access completes in cycle d+2.
- R7: Otherwise, let e be the first cycle after d in which `fetchBusy` is 0 while a cycle from d onward has already shown it at 1. The byte access completes in cycle e+3.
- R8: `ackPulse` is 0 in reset. It is 1 for exactly one cycle per access, in that access's completion cycle, and 0 in every other cycle.
- R9: With `reqWord = 1`, the access is two byte accesses of the same direction. The second starts (as its own t0) in the cycle in which the first completes. Only the second byte raises `ackPulse`.
- R10: A `reqValid` that arrives while an access is in progress, including in its acknowledge cycle, is ignored and produces no further `ackPulse`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reqValid | input | 1 | Processor starts a memory access this cycle |
| reqRead | input | 1 | 1 = read, 0 = write |
| reqWord | input | 1 | 1 = 16-bit access (two bytes), 0 = single byte |
| fetchBusy | output | 1 | Fetcher or refresh engine owns the DRAM this cycle |
| ackPulse | output | 1 | One-cycle access acknowledge |
| linePos | output | 9 | Line within the frame, 0 to 311 |
| cyclePos | output | 9 | Cycle within the line, 0 to 479 |

## Verification
The assertions check the raster invariants on every cycle: the cycle counter steps and wraps, the line counter moves only at the line wrap, there is no busy cycle in the free tail of a chunk on a video line, the acknowledge lasts a single cycle, and the memory is free in the acknowledge cycle and in the cycle before it. The exact acknowledge latency can only be shown by the bench's scenarios, because it depends on the look-ahead window, the read or write decision offset and the draining of a slot. These scenarios cover both directions at every offset within a chunk, word splitting, ignored requests, the refresh-only lines and the frame wrap, and they run against both settings of the penalty parameter.

// File: rtl/vram_arb_pkg.sv
package vram_arb_pkg;

  // Strobes from the access controller to the slot timer's wait counter
  typedef struct packed {
    logic       cntLoad;
    logic [1:0] cntVal;
  } wait_ctrl_t;

  typedef enum logic [1:0] {
    ACC_IDLE,
    ACC_DECIDE,
    ACC_SLOT,
    ACC_FINISH
  } acc_state_e;

endpackage

// File: rtl/vram_slot_timer.sv
module vram_slot_timer
  import vram_arb_pkg::*;
#(
  parameter int CHUNK_CYCLES  = 12,
  parameter int BUSY_CYCLES   = 8,
  parameter int CHUNKS        = 40,
  parameter int FRAME_LINES   = 312,
  parameter int VIDEO_LINES   = 256,
  parameter int VIDEO_GRABS   = 32,
  parameter int REFRESH_GRABS = 8,
  parameter bit FULL_PENALTY  = 1'b0,
  parameter int LOOKAHEAD     = 4
) (
  input  logic                                 clk,
  input  logic                                 rst,
  input  wait_ctrl_t                           ctrl,
  output logic                                 fetchBusy,
  output logic                                 freeAhead,
  output logic                                 cntZero,
  output logic [$clog2(FRAME_LINES)-1:0]       linePos,
  output logic [$clog2(CHUNKS*CHUNK_CYCLES)-1:0] cyclePos
);
  localparam int LINE_CYCLES = CHUNKS * CHUNK_CYCLES;
  localparam int HPOS_W  = $clog2(LINE_CYCLES);
  localparam int LINE_W  = $clog2(FRAME_LINES);
  localparam int CHUNK_W = $clog2(CHUNKS);
  localparam int CC_W    = $clog2(CHUNK_CYCLES);
  localparam logic [CC_W-1:0]    CC_LAST    = CC_W'(CHUNK_CYCLES - 1);
  localparam logic [CHUNK_W-1:0] CHUNK_LAST = CHUNK_W'(CHUNKS - 1);
  localparam logic [LINE_W-1:0]  LINE_LAST  = LINE_W'(FRAME_LINES - 1);

  logic [CC_W-1:0]    ccQ;
  logic [CHUNK_W-1:0] chunkQ;
  logic [HPOS_W-1:0]  hposQ;
  logic [LINE_W-1:0]  lineQ;
  logic [1:0]         cntQ;

  // Slot pattern: a chunk is a busy slot when its index is below the grab count
  function automatic logic slotBusy(input int ln, input int ch, input int cc);
    int grabs;
    grabs = (ln < VIDEO_LINES || FULL_PENALTY) ? VIDEO_GRABS : REFRESH_GRABS;
    return (ch < grabs) && (cc < BUSY_CYCLES);
  endfunction

  // Raster position counters
  always_ff @(posedge clk) begin
    if (rst) begin
      ccQ    <= '0;
      chunkQ <= '0;
      hposQ  <= '0;
      lineQ  <= '0;
    end else if (ccQ == CC_LAST) begin
      ccQ <= '0;
      if (chunkQ == CHUNK_LAST) begin
        chunkQ <= '0;
        hposQ  <= '0;
        lineQ  <= (lineQ == LINE_LAST) ? '0 : lineQ + 1'b1;
      end else begin
        chunkQ <= chunkQ + 1'b1;
        hposQ  <= hposQ + 1'b1;
      end
    end else begin
      ccQ   <= ccQ + 1'b1;
      hposQ <= hposQ + 1'b1;
    end
  end

  // Look-ahead over the current cycle and the next LOOKAHEAD-1
  always_comb begin
    int c, ch, ln;
    freeAhead = 1'b1;
    for (int k = 0; k < LOOKAHEAD; k++) begin
      c  = int'(ccQ) + k;
      ch = int'(chunkQ);
      ln = int'(lineQ);
      if (c >= CHUNK_CYCLES) begin
        c  = c - CHUNK_CYCLES;
        ch = ch + 1;
        if (ch >= CHUNKS) begin
          ch = 0;
          ln = (ln + 1 >= FRAME_LINES) ? 0 : ln + 1;
        end
      end
      if (slotBusy(ln, ch, c)) freeAhead = 1'b0;
    end
  end

  assign fetchBusy = slotBusy(int'(lineQ), int'(chunkQ), int'(ccQ));

  // Wait counter driven by the controller's strobes
  always_ff @(posedge clk) begin
    if (rst)               cntQ <= '0;
    else if (ctrl.cntLoad) cntQ <= ctrl.cntVal;
    else if (cntQ != 2'd0) cntQ <= cntQ - 2'd1;
  end

  assign cntZero  = (cntQ == 2'd0);
  assign linePos  = lineQ;
  assign cyclePos = hposQ;

endmodule

// File: rtl/vram_wait_ctrl.sv
module vram_wait_ctrl
  import vram_arb_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       reqValid,
  input  logic       reqRead,
  input  logic       reqWord,
  input  logic       fetchBusy,
  input  logic       freeAhead,
  input  logic       cntZero,
  output wait_ctrl_t ctrl,
  output logic       ackPulse
);
  acc_state_e stateQ;
  logic rnwQ, wordQ, secondQ, seenQ;
  logic lastByte;

  assign lastByte = !wordQ || secondQ;

  // Counter loads: read decides 2 cycles in, write 3; completion 2 cycles
  // after a clear decision, 3 after a drained slot
  always_comb begin
    ctrl = '0;
    case (stateQ)
      ACC_IDLE: if (reqValid) begin
        ctrl.cntLoad = 1'b1;
        ctrl.cntVal  = reqRead ? 2'd1 : 2'd2;
      end
      ACC_DECIDE: if (cntZero && freeAhead) begin
        ctrl.cntLoad = 1'b1;
        ctrl.cntVal  = 2'd1;
      end
      ACC_SLOT: if (!fetchBusy && seenQ) begin
        ctrl.cntLoad = 1'b1;
        ctrl.cntVal  = 2'd2;
      end
      ACC_FINISH: if (cntZero && !lastByte) begin
        ctrl.cntLoad = 1'b1;
        ctrl.cntVal  = rnwQ ? 2'd1 : 2'd2;
      end
      default: ctrl = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stateQ  <= ACC_IDLE;
      rnwQ    <= 1'b0;
      wordQ   <= 1'b0;
      secondQ <= 1'b0;
      seenQ   <= 1'b0;
    end else begin
      case (stateQ)
        ACC_IDLE: if (reqValid) begin
          rnwQ    <= reqRead;
          wordQ   <= reqWord;
          secondQ <= 1'b0;
          stateQ  <= ACC_DECIDE;
        end
        ACC_DECIDE: if (cntZero) begin
          if (freeAhead) stateQ <= ACC_FINISH;
          else begin
            seenQ  <= fetchBusy;
            stateQ <= ACC_SLOT;
          end
        end
        ACC_SLOT: begin
          if (fetchBusy) seenQ <= 1'b1;
          else if (seenQ) stateQ <= ACC_FINISH;
        end
        ACC_FINISH: if (cntZero) begin
          if (lastByte) stateQ <= ACC_IDLE;
          else begin
            secondQ <= 1'b1;
            stateQ  <= ACC_DECIDE;
          end
        end
        default: stateQ <= ACC_IDLE;
      endcase
    end
  end

  assign ackPulse = (stateQ == ACC_FINISH) && cntZero && lastByte;

endmodule

// File: rtl/vram_wait_gen.sv
module vram_wait_gen
  import vram_arb_pkg::*;
#(
  parameter int CHUNK_CYCLES  = 12,
  parameter int BUSY_CYCLES   = 8,
  parameter int CHUNKS        = 40,
  parameter int FRAME_LINES   = 312,
  parameter int VIDEO_LINES   = 256,
  parameter int VIDEO_GRABS   = 32,
  parameter int REFRESH_GRABS = 8,
  parameter bit FULL_PENALTY  = 1'b0
) (
  input  logic                                   clk,
  input  logic                                   rst,
  input  logic                                   reqValid,
  input  logic                                   reqRead,
  input  logic                                   reqWord,
  output logic                                   fetchBusy,
  output logic                                   ackPulse,
  output logic [$clog2(FRAME_LINES)-1:0]         linePos,
  output logic [$clog2(CHUNKS*CHUNK_CYCLES)-1:0] cyclePos
);
  wait_ctrl_t ctrl;
  logic freeAhead, cntZero;

  vram_slot_timer #(
    .CHUNK_CYCLES(CHUNK_CYCLES), .BUSY_CYCLES(BUSY_CYCLES), .CHUNKS(CHUNKS),
    .FRAME_LINES(FRAME_LINES), .VIDEO_LINES(VIDEO_LINES),
    .VIDEO_GRABS(VIDEO_GRABS), .REFRESH_GRABS(REFRESH_GRABS),
    .FULL_PENALTY(FULL_PENALTY), .LOOKAHEAD(4)
  ) u_timer (
    .clk(clk), .rst(rst), .ctrl(ctrl),
    .fetchBusy(fetchBusy), .freeAhead(freeAhead), .cntZero(cntZero),
    .linePos(linePos), .cyclePos(cyclePos)
  );

  vram_wait_ctrl u_ctrl (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqRead(reqRead),
    .reqWord(reqWord), .fetchBusy(fetchBusy), .freeAhead(freeAhead),
    .cntZero(cntZero), .ctrl(ctrl), .ackPulse(ackPulse)
  );

endmodule

// File: rtl/vram_wait_gen_chk.sv
module vram_wait_gen_chk #(
  parameter int CHUNK_CYCLES = 12,
  parameter int BUSY_CYCLES  = 8,
  parameter int CHUNKS       = 40,
  parameter int FRAME_LINES  = 312,
  parameter int VIDEO_LINES  = 256
) (
  input logic                                   clk,
  input logic                                   rst,
  input logic                                   fetchBusy,
  input logic                                   ackPulse,
  input logic [$clog2(FRAME_LINES)-1:0]         linePos,
  input logic [$clog2(CHUNKS*CHUNK_CYCLES)-1:0] cyclePos
);
  localparam int HPOS_W = $clog2(CHUNKS * CHUNK_CYCLES);
  localparam int LINE_W = $clog2(FRAME_LINES);
  localparam logic [HPOS_W-1:0] HPOS_LAST = HPOS_W'(CHUNKS * CHUNK_CYCLES - 1);
  localparam logic [LINE_W-1:0] LINE_LAST = LINE_W'(FRAME_LINES - 1);

  // R1
  cycle_step_chk: assert property (@(posedge clk) disable iff (rst)
    (cyclePos != HPOS_LAST) |=> (cyclePos == $past(cyclePos) + 1'b1));

  // R1
  cycle_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (cyclePos == HPOS_LAST) |=> (cyclePos == '0));

  // R1
  line_step_chk: assert property (@(posedge clk) disable iff (rst)
    (cyclePos == HPOS_LAST && linePos != LINE_LAST) |=> (linePos == $past(linePos) + 1'b1));

  // R1
  line_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (cyclePos != HPOS_LAST) |=> $stable(linePos));

  // R2
  video_tail_free_chk: assert property (@(posedge clk) disable iff (rst)
    (int'(linePos) < VIDEO_LINES && (int'(cyclePos) % CHUNK_CYCLES) >= BUSY_CYCLES) |-> !fetchBusy);

  // R8
  ack_single_chk: assert property (@(posedge clk) disable iff (rst)
    ackPulse |=> !ackPulse);

  // R6 and R7: completion only lands in a free window
  ack_free_chk: assert property (@(posedge clk) disable iff (rst)
    ackPulse |-> (!fetchBusy && !$past(fetchBusy)));

endmodule

bind vram_wait_gen vram_wait_gen_chk #(
  .CHUNK_CYCLES(CHUNK_CYCLES), .BUSY_CYCLES(BUSY_CYCLES), .CHUNKS(CHUNKS),
  .FRAME_LINES(FRAME_LINES), .VIDEO_LINES(VIDEO_LINES)
) u_chk (
  .clk(clk), .rst(rst), .fetchBusy(fetchBusy), .ackPulse(ackPulse),
  .linePos(linePos), .cyclePos(cyclePos)
);

// File: tb/vram_wait_gen_bench.sv
module vram_wait_gen_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reqValid = 1'b0, reqRead = 1'b0, reqWord = 1'b0;
  logic busyA, ackA, busyB, ackB;
  logic [8:0] lineA, cycA, lineB, cycB;

  int errors = 0;
  int checks = 0;
  longint cyc = 0;
  bit running = 1'b0;

  always #2.5 clk = ~clk;

  vram_wait_gen u_vram_wait_gen (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqRead(reqRead), .reqWord(reqWord),
    .fetchBusy(busyA), .ackPulse(ackA), .linePos(lineA), .cyclePos(cycA));

  vram_wait_gen #(.FULL_PENALTY(1'b1)) u_vram_wait_genFull (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqRead(reqRead), .reqWord(reqWord),
    .fetchBusy(busyB), .ackPulse(ackB), .linePos(lineB), .cyclePos(cycB));

  always @(posedge clk) if (!rst) cyc <= cyc + 1;

  // Reference slot pattern from R2, R3, R4
  function automatic bit busyAt(longint n, bit full);
    longint pos, ln;
    int grabs;
    pos = n % 480;
    ln  = (n / 480) % 312;
    grabs = (ln < 256 || full) ? 32 : 8;
    return ((pos / 12) < grabs) && ((pos % 12) < 8);
  endfunction

  // Completion cycle of one byte access started at t0 (R5, R6, R7)
  function automatic longint byteDone(longint t0, bit rd, bit full);
    longint d, n;
    bit seen;
    d = t0 + (rd ? 2 : 3);
    if (!busyAt(d, full) && !busyAt(d+1, full) && !busyAt(d+2, full) && !busyAt(d+3, full))
      return d + 2;
    seen = busyAt(d, full);
    n = d + 1;
    while (!(seen && !busyAt(n, full))) begin
      if (busyAt(n, full)) seen = 1'b1;
      n++;
    end
    return n + 3;
  endfunction

  // R9: the second byte starts where the first completes
  function automatic longint accessDone(longint t0, bit rd, bit wd, bit full);
    longint c;
    c = byteDone(t0, rd, full);
    if (wd) c = byteDone(c, rd, full);
    return c;
  endfunction

  task automatic check(bit ok, string tag, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at cycle %0d: actual=%0d expected=%0d", tag, cyc, act, exp);
    end
  endtask

  // Per-cycle raster and slot check (R1, R2, R3, R4)
  always @(negedge clk) begin
    if (running && !rst) begin
      check(cycA == 9'(cyc % 480), "R1 cyclePos", cycA, cyc % 480);
      check(lineA == 9'((cyc / 480) % 312), "R1 linePos", lineA, (cyc / 480) % 312);
      check(busyA == busyAt(cyc, 1'b0), ((cyc / 480) % 312) < 256 ? "R2 slot" : "R3 slot",
            busyA, busyAt(cyc, 1'b0));
      check(busyB == busyAt(cyc, 1'b1), "R4 slot", busyB, busyAt(cyc, 1'b1));
    end
  end

  // Called at a negedge; the current cycle becomes t0
  task automatic access(bit rd, bit wd, bit stray);
    longint t0, eA, eB, last, gotA, gotB;
    bit badA, badB;
    string tag;
    t0 = cyc;
    eA = accessDone(t0, rd, wd, 1'b0);
    eB = accessDone(t0, rd, wd, 1'b1);
    last = ((eA > eB) ? eA : eB) + 24;
    tag = stray ? "R10 ignored request" : (wd ? "R9 word access" : "R5 R6 R7 R8 byte access");
    gotA = -1; gotB = -1; badA = 1'b0; badB = 1'b0;
    reqRead = rd; reqWord = wd; reqValid = 1'b1;
    while (cyc < last) begin
      @(negedge clk);
      // stray requests in the next cycle and in the acknowledge cycle
      reqValid = stray && (cyc == t0 + 1 || cyc == eA);
      if (ackA && gotA < 0) gotA = cyc;
      if (ackB && gotB < 0) gotB = cyc;
      if (ackA != (cyc == eA)) badA = 1'b1;
      if (ackB != (cyc == eB)) badB = 1'b1;
    end
    reqValid = 1'b0;
    check(!badA, tag, gotA - t0, eA - t0);
    check(!badB, {tag, " R4"}, gotB - t0, eB - t0);
  endtask

  task automatic alignTo(int off);
    while ((cyc % 12) != off) @(negedge clk);
  endtask

  task automatic waitUntil(longint n);
    while (cyc < n) @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    running = 1'b1;
    // Reset state (R1, R8)
    check(cycA == 9'd0 && lineA == 9'd0, "R1 reset position", cycA, 0);
    check(ackA == 1'b0, "R8 reset ack", ackA, 0);
    check(busyA == 1'b1, "R2 line start busy", busyA, 1);
    @(negedge clk);

    // Every offset within a chunk, both directions, video line
    for (int off = 0; off < 12; off++) begin
      alignTo(off); access(1'b1, 1'b0, 1'b0);
      alignTo(off); access(1'b0, 1'b0, 1'b0);
    end
    // Word accesses at each offset
    for (int off = 0; off < 12; off++) begin
      alignTo(off); access(off[0], 1'b1, 1'b0);
    end
    // Ignored requests (R10)
    alignTo(8); access(1'b1, 1'b0, 1'b1);
    alignTo(3); access(1'b0, 1'b1, 1'b1);
    // Line end: free chunks 32..39 into next line's busy chunk 0
    waitUntil(2 * 480 + 460);
    for (int i = 0; i < 10; i++) access(i[0], i[1], 1'b0);

    // Random mix
    for (int i = 0; i < 60; i++) begin
      int gap;
      gap = int'($urandom % 20);
      repeat (gap) @(negedge clk);
      access(1'($urandom), 1'($urandom), ($urandom % 5) == 0);
    end

    // Refresh-only lines (R3) vs full penalty (R4)
    waitUntil(256 * 480 + 70);
    for (int off = 0; off < 24; off++) begin
      alignTo(off % 12); access(off[0], off >= 18, 1'b0);
    end
    // Frame wrap back into video line 0
    waitUntil(312 * 480 - 12);
    for (int i = 0; i < 6; i++) access(i[0], i[1], 1'b0);

    running = 1'b0;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog R8: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule